// File: doc/BRIEF.md
# Analog Front-End Refresh Duty-Cycle Controller

This block decides when the resistive divider and the bandgap reference of a supply supervisor are powered. After power-on, and whenever the supply is below threshold, it keeps both enabled without interruption. The block uses two inputs from the reset logic. One is the comparator's undervoltage flag. The other is a one-cycle strobe that fires when the reset hold delay has expired.

When that strobe arrives with the supply good, the controller enters a low-power regime. It turns the divider and reference off at once. It then wakes them on a fixed period for a short refresh burst, so that the values held on the sampling capacitors are topped up. The sample-and-hold switches follow the enables with one clock of lag. This way they never connect to a reference that is still settling.

Undervoltage overrides everything in the same cycle. A new strobe is required before duty cycling resumes. The period and the burst length are parameters given in clock ticks.

Top module: `afe_refresh_ctrl`

## Requirements
- R1: While reset is held and right after it, `div_en`, `ref_en`, `hold_div` and `hold_ref` are 1 and `refresh_active` is 0.
- R2: Without a release strobe the enables stay at 1 on every cycle, however long the wait.
- R3: A release strobe sampled high with `uv_flag` low drops `div_en` and `ref_en` to 0 in the cycle that follows that clock edge.
- R4: The first refresh burst starts exactly PERIOD_TICKS cycles after the first cycle with the enables off. Each later burst starts PERIOD_TICKS cycles after the start of the previous one. Every new entry into the low-power regime restarts this timing.
- R5: A burst lasts exactly BURST_TICKS cycles. During a burst `refresh_active` is 1 and both enables are 1, and outside one `refresh_active` is 0.
- R6: `uv_flag` high forces both enables to 1 in the same cycle. The block then stays in continuous mode after the flag clears, with no bursts, until a new release strobe arrives.
- R7: A release strobe during the low-power regime or a burst has no effect on the burst timing.
- R8: A release strobe sampled while `uv_flag` is high is ignored, and the enables stay at 1.
- R9: `hold_div` and `hold_ref` (1 = switch closed) copy the enable with one clock of delay. They open one cycle after the enables fall and close one cycle after the enables rise.
- R10: `uv_flag` during a burst ends it. `refresh_active` is 0 from the next cycle and the enables stay at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uv_flag | input | 1 | Comparator reports supply below threshold (1 = undervoltage) |
| rst_released | input | 1 | One-cycle strobe: the reset hold delay has completed |
| div_en | output | 1 | Enable of the resistive divider |
| ref_en | output | 1 | Enable of the bandgap reference |
| hold_div | output | 1 | Divider sample-and-hold switch, 1 = closed |
| hold_ref | output | 1 | Reference sample-and-hold switch, 1 = closed |
| refresh_active | output | 1 | High for the duration of each refresh burst |

## Verification
The hardest situations to reach are the two undervoltage interruptions. One cuts into the middle of a sleep interval and the other into the middle of a burst. In both cases the bench must also show that the period restarts from the next entry into sleep and does not carry on from the old phase. The stimulus first waits until the burst edges have been counted from the ports. It then raises the flag for a single cycle at a known offset, either inside a sleep interval or on the second cycle of a burst. Finally it issues a fresh strobe and measures the cycle distance to the next burst start.

// File: rtl/afe_refresh_pkg.sv
`timescale 1ns/1ps
package afe_refresh_pkg;

  typedef enum logic [1:0] {
    ST_CONT    = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_REFRESH = 2'd2
  } afe_state_e;

endpackage

// File: rtl/afe_tick_counter.sv
`timescale 1ns/1ps
// Wrapping tick counter: 'last' is high on the final count of LIMIT.
module afe_tick_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic last
);

  localparam int unsigned    CW       = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0]  LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign last   = (cnt_q == LAST_VAL);
  assign cnt_en = clr | run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = last ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/afe_mode_fsm.sv
`timescale 1ns/1ps
// Continuous / sleep / refresh sequencer. Undervoltage has top priority.
module afe_mode_fsm
  import afe_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_flag,
  input  logic       release_stb,
  input  logic       period_last,
  input  logic       burst_last,
  output afe_state_e state_q
);

  afe_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (uv_flag) begin
      state_d = ST_CONT;
    end else begin
      unique case (state_q)
        ST_CONT:    if (release_stb) state_d = ST_SLEEP;
        ST_SLEEP:   if (period_last) state_d = ST_REFRESH;
        ST_REFRESH: if (burst_last)  state_d = ST_SLEEP;
        default:    state_d = ST_CONT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CONT;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/afe_hold_follow.sv
`timescale 1ns/1ps
// One-clock follower per sample-and-hold switch; closed after reset.
module afe_hold_follow #(
  parameter int unsigned N_SW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_SW-1:0] gate_in,
  output logic [N_SW-1:0] hold_q
);

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[i] <= 1'b1;
      end else begin
        hold_q[i] <= gate_in[i];
      end
    end
  end

endmodule

// File: rtl/afe_refresh_ctrl.sv
`timescale 1ns/1ps
module afe_refresh_ctrl
  import afe_refresh_pkg::*;
#(
  parameter int unsigned PERIOD_TICKS = 3_000_000,
  parameter int unsigned BURST_TICKS  = 5_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_flag,
  input  logic rst_released,
  output logic div_en,
  output logic ref_en,
  output logic hold_div,
  output logic hold_ref,
  output logic refresh_active
);

  localparam int unsigned N_GATED = 2;

  logic [1:0]         rsync_q;
  logic               rst_core_n;
  afe_state_e         state_q;
  logic               period_last;
  logic               burst_last;
  logic               gate_on;
  logic [N_GATED-1:0] hold_vec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  afe_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .uv_flag     (uv_flag),
    .release_stb (rst_released),
    .period_last (period_last),
    .burst_last  (burst_last),
    .state_q     (state_q)
  );

  // period runs from sleep entry and keeps running through each burst
  afe_tick_counter #(.LIMIT(PERIOD_TICKS)) u_period (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (state_q == ST_CONT),
    .run   (state_q != ST_CONT),
    .last  (period_last)
  );

  afe_tick_counter #(.LIMIT(BURST_TICKS)) u_burst (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (state_q != ST_REFRESH),
    .run   (1'b1),
    .last  (burst_last)
  );

  // undervoltage reopens the front end without waiting for a clock edge
  assign gate_on        = uv_flag | (state_q != ST_SLEEP);
  assign div_en         = gate_on;
  assign ref_en         = gate_on;
  assign refresh_active = (state_q == ST_REFRESH);

  afe_hold_follow #(.N_SW(N_GATED)) u_hold (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .gate_in ({N_GATED{gate_on}}),
    .hold_q  (hold_vec)
  );

  assign hold_div = hold_vec[0];
  assign hold_ref = hold_vec[1];

endmodule

// File: rtl/afe_refresh_chk.sv
`timescale 1ns/1ps
module afe_refresh_chk #(
  parameter int unsigned PERIOD_TICKS = 3_000_000,
  parameter int unsigned BURST_TICKS  = 5_000
) (
  input logic clk,
  input logic rst_n,
  input logic uv_flag,
  input logic rst_released,
  input logic div_en,
  input logic ref_en,
  input logic hold_div,
  input logic hold_ref,
  input logic refresh_active
);

  int unsigned burst_len_q;
  int unsigned gap_q;
  logic        ra_prev_q;
  logic        cont_mode;

  assign cont_mode = div_en & ~refresh_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_len_q <= 0;
      gap_q       <= 0;
      ra_prev_q   <= 1'b0;
    end else begin
      ra_prev_q   <= refresh_active;
      burst_len_q <= refresh_active ? burst_len_q + 1 : 0;
      if (cont_mode) begin
        gap_q <= 0;
      end else if (refresh_active && !ra_prev_q) begin
        gap_q <= 1;
      end else begin
        gap_q <= gap_q + 1;
      end
    end
  end

  // R6
  uv_forces_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> (div_en && ref_en));

  // R9
  hold_close_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_en) |=> (hold_div && hold_ref));

  // R9
  hold_open_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_en) |=> (!hold_div && !hold_ref));

  // R3
  sleep_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_en) |-> ($past(rst_released) || $past(refresh_active)));

  // R5
  burst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_active |-> (div_en && ref_en));

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(refresh_active) && !$past(uv_flag)) |-> (burst_len_q == BURST_TICKS));

  // R4
  burst_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_active) |-> (gap_q == PERIOD_TICKS));

endmodule

bind afe_refresh_ctrl afe_refresh_chk #(
  .PERIOD_TICKS (PERIOD_TICKS),
  .BURST_TICKS  (BURST_TICKS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .uv_flag        (uv_flag),
  .rst_released   (rst_released),
  .div_en         (div_en),
  .ref_en         (ref_en),
  .hold_div       (hold_div),
  .hold_ref       (hold_ref),
  .refresh_active (refresh_active)
);

// File: tb/tb_afe_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_afe_refresh_ctrl;

  localparam int PERIOD = 40;
  localparam int BURST  = 5;

  logic clk;
  logic rst_n;
  logic uv_flag;
  logic rst_released;
  logic div_en, ref_en, hold_div, hold_ref, refresh_active;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  afe_refresh_ctrl #(.PERIOD_TICKS(PERIOD), .BURST_TICKS(BURST)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .uv_flag        (uv_flag),
    .rst_released   (rst_released),
    .div_en         (div_en),
    .ref_en         (ref_en),
    .hold_div       (hold_div),
    .hold_ref       (hold_ref),
    .refresh_active (refresh_active)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_uv();
    uv_flag = 1'b1;
    step();
    uv_flag = 1'b0;
  endtask

  task automatic enter_sleep();
    rst_released = 1'b1;
    step();
    rst_released = 1'b0;
  endtask

  // steps until a burst is seen; k counts cycles since the first sleep cycle
  task automatic wait_burst(input int k0, output int k);
    k = k0;
    while (!refresh_active && k < 4 * PERIOD) begin
      step();
      k++;
    end
  endtask

  task automatic t_reset();
    chk("R1 div_en", div_en, 1);
    chk("R1 ref_en", ref_en, 1);
    chk("R1 hold_div", hold_div, 1);
    chk("R1 hold_ref", hold_ref, 1);
    chk("R1 refresh_active", refresh_active, 0);
  endtask

  task automatic t_stay_continuous();
    int lows = 0;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      step();
      if (!div_en || !ref_en || refresh_active) lows++;
    end
    chk("R2 cycles not continuous", lows, 0);
  endtask

  task automatic t_strobe_under_uv();
    int lows = 0;
    uv_flag = 1'b1;
    rst_released = 1'b1;
    step();
    uv_flag = 1'b0;
    rst_released = 1'b0;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      if (!div_en || refresh_active) lows++;
      step();
    end
    chk("R8 cycles gated after strobe with uv", lows, 0);
  endtask

  task automatic t_duty_cycle();
    int k, len, h_rise, h_next;
    enter_sleep();
    chk("R3 div_en after strobe", div_en, 0);
    chk("R3 ref_en after strobe", ref_en, 0);
    chk("R9 hold_div still closed", hold_div, 1);
    step();
    chk("R9 hold_div opened", hold_div, 0);
    chk("R9 hold_ref opened", hold_ref, 0);
    wait_burst(1, k);
    chk("R4 first burst offset", k, PERIOD);
    chk("R5 div_en in burst", div_en, 1);
    h_rise = hold_div;
    len = 0;
    h_next = 0;
    while (refresh_active && len < 100) begin
      len++;
      if (len == 2) h_next = hold_ref;
      step();
    end
    chk("R9 hold open on burst start", h_rise, 0);
    chk("R9 hold closed one cycle later", h_next, 1);
    chk("R5 burst length", len, BURST);
    chk("R5 div_en after burst", div_en, 0);
    chk("R9 hold closed right after burst", hold_div, 1);
    wait_burst(k + len, k);
    chk("R4 second burst offset", k, 2 * PERIOD);
  endtask

  task automatic t_strobe_in_sleep();
    int k;
    pulse_uv();
    enter_sleep();
    for (int i = 0; i < 10; i++) step();
    rst_released = 1'b1;
    step();
    rst_released = 1'b0;
    wait_burst(11, k);
    chk("R7 burst offset with stray strobe", k, PERIOD);
  endtask

  task automatic t_uv_in_sleep();
    int bad_cycles = 0;
    int k;
    pulse_uv();
    enter_sleep();
    for (int i = 0; i < 5; i++) step();
    uv_flag = 1'b1;
    #1;
    chk("R6 div_en same cycle", div_en, 1);
    chk("R6 ref_en same cycle", ref_en, 1);
    step();
    uv_flag = 1'b0;
    for (int i = 0; i < 2 * PERIOD; i++) begin
      if (!div_en || refresh_active) bad_cycles++;
      step();
    end
    chk("R6 stays continuous after uv", bad_cycles, 0);
    enter_sleep();
    wait_burst(0, k);
    chk("R4 period restarts on new sleep", k, PERIOD);
  endtask

  task automatic t_uv_in_burst();
    int bad_cycles = 0;
    step();
    chk("R5 still inside burst", refresh_active, 1);
    pulse_uv();
    chk("R10 burst ended", refresh_active, 0);
    chk("R10 div_en held on", div_en, 1);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      step();
      if (!div_en || refresh_active) bad_cycles++;
    end
    chk("R10 no burst after uv", bad_cycles, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    uv_flag = 1'b0;
    rst_released = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_stay_continuous();
    t_strobe_under_uv();
    t_duty_cycle();
    t_strobe_in_sleep();
    t_uv_in_sleep();
    t_uv_in_burst();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule